// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is one eight-pin general-purpose I/O port. Software reaches it through a small byte-wide register bus and gets one setting per pin for each of these: drive direction, output level, a choice between the port and a peripheral as the output source, the interrupt edge, interrupt enable, a sticky interrupt flag and an analog-use input disable. The block drives each pad's output value and output enable. It synchronizes the pad inputs and passes them to the register bus and to the peripheral side. It records the selected edges as flags and raises one combined interrupt request.

A display segment driver can take pins away from the port through a 3-bit group count. While it holds them, the port registers have no effect on those pins. An analog-disable bit turns off a pin's driver and its digital input, so the pin can be shared with an analog comparator.

Top module: `gpio_port`

## Requirements
- R1: The registers sit at these byte offsets: input 0, output 1, direction 2, interrupt flag 3, edge select 4, interrupt enable 5, function select 6, analog disable 7. Each register from 1 to 7 reads back the value last written to it. The one exception is the flag register, whose hardware edges can also set bits.
- R2: Direction 1 makes a pin an output, so `padOe` is 1. Direction 0 makes it an input, so `padOe` is 0. When the select bit is 0, `padOut` carries the output register bit.
- R3: A select bit of 1 switches that pin's `padOut` to `altOut`. In both select settings, `altIn` carries the synchronized pad value of a live pin.
- R4: Pad inputs pass through two flops. `altIn` and the input register show a pad change after the second rising clock edge. Writes to offset 0 have no effect.
- R5: An edge-select bit of 0 sets the flag on a rising transition of the synchronized input, and 1 sets it on a falling transition. The flag becomes set on the third clock edge after the pad change. Changing the edge-select bit alone never sets a flag.
- R6: Writing the flag register loads it: a 1 sets a flag and a 0 clears it. When a hardware edge and a software clear fall in the same cycle, the edge wins. A flag never clears without a flag write.
- R7: `irq` is 1 exactly when at least one pin has both its flag and its enable set.
- R8: A pin with analog disable 1 that is not held by the segment driver has `padOe` 0 and `padOut` 0. Its input reads 0 on the bus and on `altIn`, and it never sets a flag. Clearing the bit again causes no spurious flag.
- R9: With `segGroupEn` = k, pins with index below 2k (saturating at 8) belong to the segment driver. On those pins, `padOe` is 1 and `padOut` equals `segData`. Their input reads 0 and they set no flags. Segment ownership takes priority over analog disable.
- R10: After reset, registers 1 to 7 read 0, `padOe` is 0 and `irq` is 0.
- R11: `busRdData` shows the addressed register one cycle after a `busRd` strobe. It holds that value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, valid one cycle after busRd |
| padIn | input | 8 | Raw pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| altOut | input | 8 | Peripheral output values for selected pins |
| altIn | output | 8 | Synchronized live pad inputs to peripherals |
| segGroupEn | input | 3 | Number of two-pin groups owned by the segment driver |
| segData | input | 8 | Segment driver output values |
| irq | output | 1 | Combined interrupt request |

## Verification
The checker tests several things on every cycle. Segment-owned pins are always driven with `segData`. Analog-disabled pins never enable their driver. Output enables follow the direction register. Flags never fall without a flag write. An analog-disabled pin never raises a flag. Read data holds between strobes. Only the bench scenarios can show the edge polarity, the three-cycle flag latency, the edge-over-clear priority, the fact that changing the edge select raises no flag, and the read-only input register, because each of these needs a timed sequence of pad and bus events.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PIN_CNT  = 8;
  localparam int ADDR_W   = 3;
  localparam int GRP_SIZE = 2;

  typedef enum logic [ADDR_W-1:0] {
    OFF_IN   = 3'd0,
    OFF_OUT  = 3'd1,
    OFF_DIR  = 3'd2,
    OFF_FLG  = 3'd3,
    OFF_EDGE = 3'd4,
    OFF_EN   = 3'd5,
    OFF_SEL  = 3'd6,
    OFF_ADIS = 3'd7
  } regOff_e;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrFlg;
    logic wrEdge;
    logic wrEn;
    logic wrSel;
    logic wrAdis;
    logic rdStb;
    logic [ADDR_W-1:0] rdAddr;
  } gpioStb_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output gpioStb_t          stb
);
  always_comb begin
    stb        = '0;
    stb.rdStb  = busRd;
    stb.rdAddr = busAddr;
    if (busWr) begin
      unique case (regOff_e'(busAddr))
        OFF_OUT:  stb.wrOut  = 1'b1;
        OFF_DIR:  stb.wrDir  = 1'b1;
        OFF_FLG:  stb.wrFlg  = 1'b1;
        OFF_EDGE: stb.wrEdge = 1'b1;
        OFF_EN:   stb.wrEn   = 1'b1;
        OFF_SEL:  stb.wrSel  = 1'b1;
        OFF_ADIS: stb.wrAdis = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int PINS  = PIN_CNT,
  parameter int GRP   = GRP_SIZE,
  parameter int SEG_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStb_t         stb,
  input  logic [PINS-1:0]  wrData,
  output logic [PINS-1:0]  rdData,
  input  logic [PINS-1:0]  padIn,
  output logic [PINS-1:0]  padOut,
  output logic [PINS-1:0]  padOe,
  input  logic [PINS-1:0]  altOut,
  output logic [PINS-1:0]  altIn,
  input  logic [SEG_W-1:0] segGroupEn,
  input  logic [PINS-1:0]  segData,
  output logic             irq,
  output logic [PINS-1:0]  dirQ,
  output logic [PINS-1:0]  adisQ,
  output logic [PINS-1:0]  flgQ
);
  logic [PINS-1:0] outQ, edgeQ, enQ, selQ;
  logic [PINS-1:0] syncA, syncB, prevQ;
  logic [PINS-1:0] segMask, liveMask, inView, hitVec;

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      segMask[i] = (int'(segGroupEn) * GRP) > i;
    end
  end

  assign liveMask = ~adisQ & ~segMask;
  assign inView   = syncB & liveMask;
  assign hitVec   = liveMask & ((~edgeQ & syncB & ~prevQ) | (edgeQ & ~syncB & prevQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      dirQ  <= '0;
      flgQ  <= '0;
      edgeQ <= '0;
      enQ   <= '0;
      selQ  <= '0;
      adisQ <= '0;
    end else begin
      if (stb.wrOut)  outQ  <= wrData;
      if (stb.wrDir)  dirQ  <= wrData;
      if (stb.wrEdge) edgeQ <= wrData;
      if (stb.wrEn)   enQ   <= wrData;
      if (stb.wrSel)  selQ  <= wrData;
      if (stb.wrAdis) adisQ <= wrData;
      flgQ <= (stb.wrFlg ? wrData : flgQ) | hitVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdStb) begin
      unique case (regOff_e'(stb.rdAddr))
        OFF_IN:   rdData <= inView;
        OFF_OUT:  rdData <= outQ;
        OFF_DIR:  rdData <= dirQ;
        OFF_FLG:  rdData <= flgQ;
        OFF_EDGE: rdData <= edgeQ;
        OFF_EN:   rdData <= enQ;
        OFF_SEL:  rdData <= selQ;
        OFF_ADIS: rdData <= adisQ;
        default:  rdData <= '0;
      endcase
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    always_comb begin
      if (segMask[g]) begin
        padOe[g]  = 1'b1;
        padOut[g] = segData[g];
      end else if (adisQ[g]) begin
        padOe[g]  = 1'b0;
        padOut[g] = 1'b0;
      end else begin
        padOe[g]  = dirQ[g];
        padOut[g] = selQ[g] ? altOut[g] : outQ[g];
      end
    end
  end

  assign altIn = inView;
  assign irq   = |(flgQ & enQ);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic       busWr,
  input  logic       busRd,
  output logic [7:0] busRdData,
  input  logic [7:0] padIn,
  output logic [7:0] padOut,
  output logic [7:0] padOe,
  input  logic [7:0] altOut,
  output logic [7:0] altIn,
  input  logic [2:0] segGroupEn,
  input  logic [7:0] segData,
  output logic       irq
);
  gpioStb_t   stb;
  logic [7:0] dirQ, adisQ, flgQ;

  gpio_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  gpio_datapath #(.PINS(PIN_CNT), .GRP(GRP_SIZE), .SEG_W(3)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (busWrData),
    .rdData     (busRdData),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .altOut     (altOut),
    .altIn      (altIn),
    .segGroupEn (segGroupEn),
    .segData    (segData),
    .irq        (irq),
    .dirQ       (dirQ),
    .adisQ      (adisQ),
    .flgQ       (flgQ)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic [7:0] busRdData,
  input logic [7:0] padOut,
  input logic [7:0] padOe,
  input logic [2:0] segGroupEn,
  input logic [7:0] segData,
  input logic [7:0] dirQ,
  input logic [7:0] adisQ,
  input logic [7:0] flgQ
);
  logic flgWr;
  assign flgWr = busWr && (busAddr == 3'd3);

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (segGroupEn == 3'd0) |-> ((padOe | adisQ) == (dirQ | adisQ))); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flgWr) |-> (($past(flgQ) & ~flgQ) == 8'h00)); // R6

  AST_ANALOG_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (segGroupEn == 3'd0) |-> ((padOe & adisQ) == 8'h00)); // R8

  AST_ANALOG_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flgWr) |-> ((flgQ & ~$past(flgQ) & $past(adisQ)) == 8'h00)); // R8

  AST_SEG_ALL_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    (segGroupEn == 3'd7) |-> (padOe == 8'hFF && padOut == segData)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busRd) |-> $stable(busRdData)); // R11
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRd      (busRd),
  .busRdData  (busRdData),
  .padOut     (padOut),
  .padOe      (padOe),
  .segGroupEn (segGroupEn),
  .segData    (segData),
  .dirQ       (dirQ),
  .adisQ      (adisQ),
  .flgQ       (flgQ)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdData;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe, altIn;
  logic [7:0] altOut = '0;
  logic [2:0] segGroupEn = '0;
  logic [7:0] segData = '0;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .altOut(altOut), .altIn(altIn),
    .segGroupEn(segGroupEn), .segData(segData), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic setPad(input logic [7:0] v);
    padIn = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    for (int a = 1; a < 8; a++) begin
      rdReg(3'(a), d);
      check($sformatf("R10 reset reg %0d", a), d, 8'h00);
    end
    check("R10 reset padOe", padOe, 8'h00);
    check("R10 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_regmap();
    logic [7:0] d;
    wrReg(3'd0, 8'hFF);
    rdReg(3'd0, d);
    check("R4 input read-only", d, 8'h00);
    for (int a = 1; a < 8; a++) begin
      wrReg(3'(a), 8'(8'h11 * a) ^ 8'hA5);
      rdReg(3'(a), d);
      check($sformatf("R1 readback reg %0d", a), d, 8'(8'h11 * a) ^ 8'hA5);
    end
    for (int a = 1; a < 8; a++) wrReg(3'(a), 8'h00);
  endtask

  task automatic test_dirout();
    wrReg(3'd2, 8'h0F);
    wrReg(3'd1, 8'h33);
    check("R2 padOe from direction", padOe, 8'h0F);
    check("R2 padOut from output reg", padOut, 8'h33);
  endtask

  task automatic test_select();
    altOut = 8'hF0;
    wrReg(3'd6, 8'hF0);
    check("R3 selected pins take altOut", padOut, 8'hF3);
    setPad(8'h5A);
    check("R3 altIn with select", altIn, 8'h5A);
    wrReg(3'd6, 8'h00);
    setPad(8'h00);
    wrReg(3'd3, 8'h00);
    wrReg(3'd2, 8'h00);
    wrReg(3'd1, 8'h00);
  endtask

  task automatic test_sync();
    logic [7:0] d;
    padIn = 8'h81;
    @(posedge clk); @(negedge clk);
    check("R4 one edge not yet visible", altIn, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R4 visible after second edge", altIn, 8'h81);
    rdReg(3'd0, d);
    check("R4 input register", d, 8'h81);
    rdReg(3'd3, d);
    check("R5 rising flags", d, 8'h81);
    wrReg(3'd3, 8'h00);
    setPad(8'h00);
    wrReg(3'd3, 8'h00);
  endtask

  task automatic test_edges();
    logic [7:0] d;
    wrReg(3'd4, 8'hF0);
    setPad(8'hFF);
    rdReg(3'd3, d);
    check("R5 rising edge sets low nibble", d, 8'h0F);
    wrReg(3'd3, 8'h00);
    setPad(8'h00);
    rdReg(3'd3, d);
    check("R5 falling edge sets high nibble", d, 8'hF0);
    wrReg(3'd3, 8'h00);
    setPad(8'hFF);
    wrReg(3'd3, 8'h00);
    wrReg(3'd4, 8'h0F);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rdReg(3'd3, d);
    check("R5 edge-select change alone", d, 8'h00);
    wrReg(3'd4, 8'h00);
    setPad(8'h00);
    wrReg(3'd3, 8'h00);
  endtask

  task automatic test_flags();
    logic [7:0] d;
    wrReg(3'd3, 8'h42);
    rdReg(3'd3, d);
    check("R6 software set", d, 8'h42);
    wrReg(3'd3, 8'h00);
    rdReg(3'd3, d);
    check("R6 software clear", d, 8'h00);
    wrReg(3'd3, 8'h01);
    padIn = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wrReg(3'd3, 8'h00);
    rdReg(3'd3, d);
    check("R6 edge beats clear", d, 8'h01);
    wrReg(3'd3, 8'h00);
    setPad(8'h00);
  endtask

  task automatic test_irq();
    wrReg(3'd5, 8'h10);
    wrReg(3'd3, 8'h01);
    check("R7 flag without enable", {7'd0, irq}, 8'h00);
    wrReg(3'd3, 8'h11);
    check("R7 flag with enable", {7'd0, irq}, 8'h01);
    wrReg(3'd5, 8'h00);
    check("R7 enable removed", {7'd0, irq}, 8'h00);
    wrReg(3'd3, 8'h00);
  endtask

  task automatic test_analog();
    logic [7:0] d;
    wrReg(3'd2, 8'hFF);
    wrReg(3'd1, 8'hFF);
    wrReg(3'd7, 8'h02);
    check("R8 analog pin output off", padOe, 8'hFD);
    check("R8 analog pin output value", padOut, 8'hFD);
    setPad(8'h02);
    rdReg(3'd0, d);
    check("R8 analog input reads 0", d, 8'h00);
    check("R8 analog altIn", altIn, 8'h00);
    rdReg(3'd3, d);
    check("R8 analog no flag", d, 8'h00);
    wrReg(3'd7, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rdReg(3'd0, d);
    check("R8 input back after enable", d, 8'h02);
    rdReg(3'd3, d);
    check("R8 no spurious flag", d, 8'h00);
    setPad(8'h00);
    wrReg(3'd3, 8'h00);
    wrReg(3'd2, 8'h00);
    wrReg(3'd1, 8'h00);
  endtask

  task automatic test_segment();
    logic [7:0] d;
    wrReg(3'd7, 8'h01);
    segData = 8'h0A;
    segGroupEn = 3'd2;
    @(negedge clk);
    check("R9 segment output enables", padOe, 8'h0F);
    check("R9 segment output data", padOut, 8'h0A);
    setPad(8'hFF);
    rdReg(3'd0, d);
    check("R9 segment pins read 0", d, 8'hF0);
    rdReg(3'd3, d);
    check("R9 segment pins set no flags", d, 8'hF0);
    segGroupEn = 3'd0;
    wrReg(3'd7, 8'h00);
    setPad(8'h00);
    wrReg(3'd3, 8'h00);
  endtask

  task automatic test_rdhold();
    logic [7:0] d;
    wrReg(3'd5, 8'h3C);
    rdReg(3'd5, d);
    check("R11 read after one cycle", d, 8'h3C);
    wrReg(3'd5, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 read data holds", busRdData, 8'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_regmap();
    test_dirout();
    test_select();
    test_sync();
    test_edges();
    test_flags();
    test_irq();
    test_analog();
    test_segment();
    test_rdhold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule